// File: doc/BRIEF.md
# Timer-Driven Clock Output Pins

This block is the output stage for a small group of port pins that can each carry either a static level from the port data latch or a generated clock. The low-numbered pins are toggle pins: each one has its own toggle flop that inverts on every overflow strobe from its timer, so the pin runs at half that timer's overflow rate. The remaining pins are generator pins, which pass the baseband generator clock straight through. A per-pin mode bit picks the source, and changes to it take effect at a clock edge. Clearing the bit hands the pin back to its latch level.

Overflow strobes are one system-clock cycle wide and are sampled on that clock. When a toggle mode is switched on, the toggle flop first takes the current latch value. The pin level therefore does not jump at the switch, and the first overflow changes it. The latch itself sits outside this block and is an input here. Latch writes made while a pin is in clock mode are kept by the latch but stay off the pin until the mode is cleared.

Top module: `clkout_pins`

## Requirements
- R1: While reset is asserted and after it is released, every mode is inactive and each pin equals its `lat_i` bit. With `lat_i` at zero, all pins read zero.
- R2: On the clock edge where toggle pin i's `mode_i[i]` is first sampled as 1 with no overflow, the toggle flop loads `lat_i[i]`. From that edge the pin shows that value.
- R3: While a toggle pin is in clock mode, each cycle with `ovf_i[i]`=1 inverts the pin at the next edge. Over a run of strobes the pin completes one period per two overflows.
- R4: If an overflow strobe falls in the same cycle as the enabling edge of R2, the pin shows the inverse of `lat_i[i]` from that edge.
- R5: On the edge where a pin's mode bit is sampled as 0, the pin returns to following `lat_i` for that pin. A mode change never alters a pin before the next clock edge.
- R6: While a toggle pin is in clock mode, the pin holds its level in cycles without an overflow strobe, whatever `lat_i` does.
- R7: Overflow strobes seen while a toggle pin's mode is off have no effect. The pin keeps following the latch, and a later enable still loads the latch value.
- R8: Generator pins (indices N_TOG and up) equal `gen_clk_i` while their mode has been sampled as 1, and equal their `lat_i` bit otherwise.
- R9: Channels are independent: the overflow strobe of one timer never changes another toggle pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | N_TOG+N_GEN | Per-pin clock-mode select, 1 = clock source |
| ovf_i | input | N_TOG | One-cycle timer overflow strobes, bit i for toggle pin i |
| gen_clk_i | input | 1 | Baseband generator clock |
| lat_i | input | N_TOG+N_GEN | Port data latch levels |
| pin_o | output | N_TOG+N_GEN | Pin levels |

## Verification
The case that needs care is an overflow strobe arriving in the same cycle that a toggle pin's mode is switched on. There the latch load and the inversion must combine, and the pin must show the inverse of the latch. The same clash occurs when the mode is cleared in a cycle that also carries a strobe; the strobe must then be lost. A long pseudo-random sweep changes modes rarely and strobes and latch bits often, so these coincidences come up many times per pin, along with latch changes during clock mode. Each pin is judged every cycle against a model built from the requirements, and a directed phase then confirms that one timer's strobes leave the other toggle pin alone.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    typedef struct packed {
        logic en;
        logic tog;
    } tog_state_t;

    typedef struct packed {
        logic en;
    } gen_state_t;

endpackage

// File: rtl/clkout_tog_chan.sv
module clkout_tog_chan
    import clkout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic ovf_i,
    input  logic lat_i,
    output logic pin_o
);

    tog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_i) begin
            if (!st_q.en) begin
                // entering clock mode: seed from latch, fold in a coincident strobe
                st_d.tog = lat_i ^ ovf_i;
            end else begin
                st_d.tog = st_q.tog ^ ovf_i;
            end
        end
        st_d.en = mode_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.en ? st_q.tog : lat_i;

endmodule

// File: rtl/clkout_gen_chan.sv
module clkout_gen_chan
    import clkout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic gen_clk_i,
    input  logic lat_i,
    output logic pin_o
);

    gen_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = mode_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.en ? gen_clk_i : lat_i;

endmodule

// File: rtl/clkout_pins.sv
module clkout_pins #(
    parameter int N_TOG = 2,
    parameter int N_GEN = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_TOG+N_GEN-1:0]   mode_i,
    input  logic [N_TOG-1:0]         ovf_i,
    input  logic                     gen_clk_i,
    input  logic [N_TOG+N_GEN-1:0]   lat_i,
    output logic [N_TOG+N_GEN-1:0]   pin_o
);

    localparam int N_PIN = N_TOG + N_GEN;

    for (genvar i = 0; i < N_TOG; i++) begin : g_tog
        clkout_tog_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (mode_i[i]),
            .ovf_i  (ovf_i[i]),
            .lat_i  (lat_i[i]),
            .pin_o  (pin_o[i])
        );
    end

    for (genvar j = N_TOG; j < N_PIN; j++) begin : g_gen
        clkout_gen_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode_i[j]),
            .gen_clk_i (gen_clk_i),
            .lat_i     (lat_i[j]),
            .pin_o     (pin_o[j])
        );
    end

endmodule

// File: rtl/clkout_pins_chk.sv
module clkout_pins_chk #(
    parameter int N_TOG = 2,
    parameter int N_GEN = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_TOG+N_GEN-1:0] mode_i,
    input logic [N_TOG-1:0]       ovf_i,
    input logic                   gen_clk_i,
    input logic [N_TOG+N_GEN-1:0] lat_i,
    input logic [N_TOG+N_GEN-1:0] pin_o
);

    localparam int N_PIN = N_TOG + N_GEN;

    // mode as seen at the previous edge, kept by the checker itself
    logic [N_PIN-1:0] seen_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_mode <= '0;
        else        seen_mode <= mode_i;
    end

    for (genvar i = 0; i < N_TOG; i++) begin : g_tp
        p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!seen_mode[i] && mode_i[i] && !ovf_i[i]) |=> (pin_o[i] == $past(lat_i[i])));
        p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_mode[i] && mode_i[i] && ovf_i[i]) |=> (pin_o[i] != $past(pin_o[i])));
        p_coincide_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!seen_mode[i] && mode_i[i] && ovf_i[i]) |=> (pin_o[i] != $past(lat_i[i])));
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_mode[i] && mode_i[i] && !ovf_i[i]) |=> $stable(pin_o[i]));
    end

    for (genvar k = 0; k < N_PIN; k++) begin : g_lp
        p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !seen_mode[k] |-> (pin_o[k] == lat_i[k]));
    end

    for (genvar j = N_TOG; j < N_PIN; j++) begin : g_gp
        p_gen_r8: assert property (@(posedge clk) disable iff (!rst_n)
            seen_mode[j] |-> (pin_o[j] == gen_clk_i));
    end

endmodule

bind clkout_pins clkout_pins_chk #(.N_TOG(N_TOG), .N_GEN(N_GEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .ovf_i     (ovf_i),
    .gen_clk_i (gen_clk_i),
    .lat_i     (lat_i),
    .pin_o     (pin_o)
);

// File: tb/sim_clkout_pins.sv
`timescale 1ns/1ps
module sim_clkout_pins;

    localparam int NT = 2;
    localparam int NG = 1;
    localparam int NP = NT + NG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] mode = '0;
    logic [NT-1:0] ovf = '0;
    logic          gclk = 1'b0;
    logic [NP-1:0] lat = '0;
    logic [NP-1:0] pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state derived from the requirements
    logic [NP-1:0] m_en = '0;
    logic [NT-1:0] m_tog = '0;

    always #2 clk = ~clk;

    clkout_pins #(.N_TOG(NT), .N_GEN(NG)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .ovf_i(ovf),
        .gen_clk_i(gclk), .lat_i(lat), .pin_o(pin)
    );

    task automatic check(input string req, input int idx, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pin%0d actual=%b expected=%b t=%0t", req, idx, act, exp, $time);
        end
    endtask

    // drive at falling edge, clock once, sample just after the rising edge
    task automatic step(input logic [NP-1:0] m, input logic [NT-1:0] o,
                        input logic [NP-1:0] l, input logic g, input string force_tag);
        string tag [NP];
        @(negedge clk);
        mode = m; ovf = o; lat = l; gclk = g;
        for (int i = 0; i < NT; i++) begin
            if (!m[i])         tag[i] = o[i] ? "R7" : "R5";
            else if (!m_en[i]) tag[i] = o[i] ? "R4" : "R2";
            else               tag[i] = o[i] ? "R3" : "R6";
            if (force_tag != "") tag[i] = force_tag;
            if (m[i]) m_tog[i] = m_en[i] ? (m_tog[i] ^ o[i]) : (l[i] ^ o[i]);
        end
        for (int j = NT; j < NP; j++) tag[j] = "R8";
        m_en = m;
        @(posedge clk);
        #1;
        for (int i = 0; i < NT; i++) check(tag[i], i, pin[i], m_en[i] ? m_tog[i] : lat[i]);
        for (int j = NT; j < NP; j++) check(tag[j], j, pin[j], m_en[j] ? gclk : lat[j]);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [NP-1:0] mr;
        logic          p0;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < NP; k++) check("R1", k, pin[k], 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        for (int k = 0; k < NP; k++) check("R1", k, pin[k], 1'b0);

        // R2/R3: enable pin0 from latch 1, then count flips per strobe
        step(3'b001, 2'b00, 3'b001, 1'b0, "");
        for (int n = 0; n < 6; n++) step(3'b001, 2'b01, 3'b000, 1'b0, "");

        // R9: timer 1 strobes leave pin0 untouched
        p0 = pin[0];
        for (int n = 0; n < 4; n++) begin
            step(3'b001, 2'b10, 3'b110, 1'b1, "R9");
            check("R9", 0, pin[0], p0);
        end

        // R5: clear with a coincident strobe
        step(3'b000, 2'b01, 3'b011, 1'b0, "R5");

        // R7 then R4: strobes while off, then enable with a strobe
        step(3'b000, 2'b11, 3'b010, 1'b0, "R7");
        step(3'b010, 2'b10, 3'b010, 1'b0, "R4");

        // near-exhaustive pseudo-random sweep
        r  = 32'h1bad_5eed;
        mr = '0;
        for (int s = 0; s < 20000; s++) begin
            r  = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            mr = mr ^ (r[7:5] & r[10:8] & r[13:11]);
            step(mr, r[15:14], r[18:16], r[19], "");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule